// File: doc/BRIEF.md
# Serial Link Power and Loopback Controller

This block manages the operating mode of a byte-oriented link controller on a single-wire serial network. It follows processor stop and wait requests and moves among three power states: run, wait and stop. In stop the internal clock enable is dropped. A sticky wake-up interrupt is raised by the event that suits the current state. In wait that event is a valid end-of-frame strobe from the framing logic. In stop it is any edge seen on the raw receive pin. A processor clear strobe drops the flag and returns the block to run.

The block also places the link in one of two loopback arrangements. In digital loopback, the transmit and receive lines from the framing logic are cut off from the transceiver pins and tied to each other, and the transmit pin rests at the passive level. In analog loopback the digital paths stay as they are, because the loop is closed in the external transceiver. Loopback control changes take effect only when the bus is idle. When analog loopback is left, a participation-enable output stays low until the bus has been quiet for a further full idle interval. This stops the framing logic from transmitting into traffic it has not yet seen.

Top module: `link_mode_ctrl`

## Requirements
- R1: While `rst` is high, the outputs take these values: `mode_state`=0, `clk_en`=1, `wake_irq`=0, `part_en`=0, `tx_pin`=0, `rx_core`=0, and both loopback-active outputs 0.
- R2: In run (`mode_state`=0), a stop request moves the block to stop (`mode_state`=2). A wait request with `wait_clk_stop`=1 also moves it to stop. A wait request with `wait_clk_stop`=0 moves it to wait (`mode_state`=1). A stop request wins over a wait request. Requests made in wait or stop are ignored.
- R3: In stop, `clk_en` is 0 until a wake event occurs. Any change of `rx_pin` between consecutive cycles is a wake event in stop: it sets `wake_irq` and brings `clk_en` back to 1 at the same clock edge.
- R4: In wait, `eof_valid` sets `wake_irq`, and `rx_pin` edges are ignored. In stop, `eof_valid` is ignored.
- R5: `wake_irq` stays set until `irq_clear`. A clear that meets a pending flag drops it and sets `mode_state` to 0. A clear with no flag pending has no effect.
- R6: With digital loopback active, `rx_core` repeats `tx_core` one cycle later and `rx_pin` is ignored. Without it, `rx_core` repeats `rx_pin` and `tx_pin` repeats `tx_core`, each one cycle later.
- R7: With digital loopback active, `tx_pin` is held at the passive level 0.
- R8: With analog loopback active, the transmit and receive paths behave as in the no-loopback case of R6.
- R9: The bus counts as idle once `rx_core` has been 0 for `IDLE_CYCLES` consecutive cycles. `dig_loop_req` and `ana_loop_req` are copied to the loopback-active outputs only while the bus is idle.
- R10: When analog loopback becomes inactive, `part_en` goes low and stays low until `rx_core` has again been 0 for `IDLE_CYCLES` consecutive cycles. Any activity in that window restarts the count.
- R11: `part_en` is 0 whenever `mode_state` is 2, and 1 in run or wait when no R10 holdoff is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_stop_req | input | 1 | Processor stop request |
| cpu_wait_req | input | 1 | Processor wait request |
| wait_clk_stop | input | 1 | When set, a wait request stops the clocks |
| dig_loop_req | input | 1 | Digital loopback control bit |
| ana_loop_req | input | 1 | Analog loopback control bit |
| eof_valid | input | 1 | Valid end-of-frame strobe from framing logic |
| irq_clear | input | 1 | Processor clear of the wake-up flag |
| rx_pin | input | 1 | Raw receive line from the transceiver |
| tx_core | input | 1 | Transmit line from framing logic |
| tx_pin | output | 1 | Transmit line to the transceiver |
| rx_core | output | 1 | Receive line to framing logic |
| clk_en | output | 1 | Internal clock enable |
| wake_irq | output | 1 | Sticky wake-up interrupt request |
| part_en | output | 1 | Bus participation enable for the transmitter |
| mode_state | output | 2 | 0 run, 1 wait, 2 stop |
| dig_loop_active | output | 1 | Digital loopback in force |
| ana_loop_active | output | 1 | Analog loopback in force |

## Verification
The hardest state to reach is the holdoff after analog loopback is left. The loop request must first be applied during a quiet interval. It must then be removed during another quiet interval. The holdoff also has to be interrupted partway by bus activity to show that the count starts over. The stimulus reaches this by waiting out idle windows a few cycles longer than `IDLE_CYCLES`, toggling the loop bit, and pulsing `rx_pin` in the middle of the holdoff. It then checks `part_en` at points before and after the restarted window has run out.

// File: rtl/link_mode_pkg.sv
package link_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_STOP = 2'd2
  } link_mode_e;

  localparam logic LINE_PASSIVE = 1'b0;
endpackage

// File: rtl/bus_idle_timer.sv
module bus_idle_timer
  import link_mode_pkg::*;
#(
  parameter int IDLE_CYCLES = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic line,
  input  logic restart,
  output logic idle
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (line != LINE_PASSIVE) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign idle = (cnt_q == LIMIT);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(idle) |-> $past(line == LINE_PASSIVE)); // R9
endmodule

// File: rtl/line_router.sv
module line_router
  import link_mode_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dig_on,
  input  logic tx_core,
  input  logic rx_pin,
  output logic tx_pin,
  output logic rx_core
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pin  <= LINE_PASSIVE;
      rx_core <= LINE_PASSIVE;
    end else if (dig_on) begin
      tx_pin  <= LINE_PASSIVE;
      rx_core <= tx_core;
    end else begin
      tx_pin  <= tx_core;
      rx_core <= rx_pin;
    end
  end

  AST_DIG_TX_PASSIVE: assert property (@(posedge clk) disable iff (rst)
    $past(dig_on) |-> (tx_pin == LINE_PASSIVE)); // R7
  AST_DIG_RX_LOOP: assert property (@(posedge clk) disable iff (rst)
    $past(dig_on) |-> (rx_core == $past(tx_core))); // R6
endmodule

// File: rtl/power_mode_fsm.sv
module power_mode_fsm
  import link_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req,
  input  logic       wait_req,
  input  logic       wait_clk_stop,
  input  logic       eof_valid,
  input  logic       bus_edge,
  input  logic       irq_clear,
  input  logic       holdoff_next,
  output link_mode_e mode_q,
  output logic       clk_en_q,
  output logic       irq_q,
  output logic       part_en_q
);
  link_mode_e mode_d;
  logic irq_set, irq_d;

  always_comb begin
    mode_d  = mode_q;
    irq_set = 1'b0;
    unique case (mode_q)
      MODE_RUN: begin
        if (stop_req)      mode_d = MODE_STOP;
        else if (wait_req) mode_d = wait_clk_stop ? MODE_STOP : MODE_WAIT;
      end
      MODE_WAIT: irq_set = eof_valid;
      MODE_STOP: irq_set = bus_edge;
      default:   mode_d  = MODE_RUN;
    endcase
    if (irq_q && irq_clear) mode_d = MODE_RUN;
    irq_d = (irq_q & ~irq_clear) | irq_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_RUN;
      irq_q     <= 1'b0;
      clk_en_q  <= 1'b1;
      part_en_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      irq_q     <= irq_d;
      clk_en_q  <= !((mode_d == MODE_STOP) && !irq_d);
      part_en_q <= (mode_d != MODE_STOP) && !holdoff_next;
    end
  end

  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN && stop_req) |=> (mode_q == MODE_STOP)); // R2
  AST_CLK_GATED: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_STOP && !irq_q) |-> !clk_en_q); // R3
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !irq_clear) |=> irq_q); // R5
  AST_STOP_NO_PART: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_STOP) |-> !part_en_q); // R11
endmodule

// File: rtl/link_mode_ctrl.sv
module link_mode_ctrl
  import link_mode_pkg::*;
#(
  parameter int IDLE_CYCLES = 300
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cpu_stop_req,
  input  logic       cpu_wait_req,
  input  logic       wait_clk_stop,
  input  logic       dig_loop_req,
  input  logic       ana_loop_req,
  input  logic       eof_valid,
  input  logic       irq_clear,
  input  logic       rx_pin,
  input  logic       tx_core,
  output logic       tx_pin,
  output logic       rx_core,
  output logic       clk_en,
  output logic       wake_irq,
  output logic       part_en,
  output logic [1:0] mode_state,
  output logic       dig_loop_active,
  output logic       ana_loop_active
);
  logic rx_prev_q, dig_app_q, ana_app_q, holdoff_q;
  logic bus_idle, ana_exit, holdoff_d;
  link_mode_e mode_q;

  assign ana_exit  = bus_idle & ana_app_q & ~ana_loop_req;
  assign holdoff_d = ana_exit | (holdoff_q & ~bus_idle);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_prev_q <= LINE_PASSIVE;
      dig_app_q <= 1'b0;
      ana_app_q <= 1'b0;
      holdoff_q <= 1'b0;
    end else begin
      rx_prev_q <= rx_pin;
      holdoff_q <= holdoff_d;
      if (bus_idle) begin
        dig_app_q <= dig_loop_req;
        ana_app_q <= ana_loop_req;
      end
    end
  end

  bus_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst(rst), .line(rx_core), .restart(ana_exit), .idle(bus_idle)
  );

  line_router u_route (
    .clk(clk), .rst(rst), .dig_on(dig_app_q), .tx_core(tx_core),
    .rx_pin(rx_pin), .tx_pin(tx_pin), .rx_core(rx_core)
  );

  power_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .stop_req(cpu_stop_req), .wait_req(cpu_wait_req),
    .wait_clk_stop(wait_clk_stop), .eof_valid(eof_valid),
    .bus_edge(rx_pin ^ rx_prev_q), .irq_clear(irq_clear),
    .holdoff_next(holdoff_d), .mode_q(mode_q), .clk_en_q(clk_en),
    .irq_q(wake_irq), .part_en_q(part_en)
  );

  assign mode_state      = mode_q;
  assign dig_loop_active = dig_app_q;
  assign ana_loop_active = ana_app_q;

  AST_APPLY_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$stable(dig_app_q) || !$stable(ana_app_q)) |-> $past(bus_idle)); // R9
  AST_HOLDOFF_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    holdoff_q |-> !part_en); // R10
endmodule

// File: tb/sim_link_mode_ctrl.sv
module sim_link_mode_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_stop_req = 0, cpu_wait_req = 0, wait_clk_stop = 0;
  logic dig_loop_req = 0, ana_loop_req = 0, eof_valid = 0, irq_clear = 0;
  logic rx_pin = 0, tx_core = 0;
  logic tx_pin, rx_core, clk_en, wake_irq, part_en;
  logic [1:0] mode_state;
  logic dig_loop_active, ana_loop_active;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  link_mode_ctrl u0 (
    .clk(clk), .rst(rst), .cpu_stop_req(cpu_stop_req), .cpu_wait_req(cpu_wait_req),
    .wait_clk_stop(wait_clk_stop), .dig_loop_req(dig_loop_req),
    .ana_loop_req(ana_loop_req), .eof_valid(eof_valid), .irq_clear(irq_clear),
    .rx_pin(rx_pin), .tx_core(tx_core), .tx_pin(tx_pin), .rx_core(rx_core),
    .clk_en(clk_en), .wake_irq(wake_irq), .part_en(part_en),
    .mode_state(mode_state), .dig_loop_active(dig_loop_active),
    .ana_loop_active(ana_loop_active)
  );

  // stimulus {stop,wait,wcm,eof,clr,rx} , expected {mode[1:0],clk_en,irq,part_en}
  localparam int NV = 23;
  localparam logic [10:0] VEC [NV] = '{
    {6'b000000, 5'b00101}, {6'b010000, 5'b01101}, {6'b000001, 5'b01101},
    {6'b000101, 5'b01111}, {6'b000001, 5'b01111}, {6'b000011, 5'b00101},
    {6'b011001, 5'b10000}, {6'b000101, 5'b10000}, {6'b000000, 5'b10110},
    {6'b000000, 5'b10110}, {6'b000010, 5'b00101}, {6'b100000, 5'b10000},
    {6'b110000, 5'b10000}, {6'b000001, 5'b10110}, {6'b100011, 5'b00101},
    {6'b100001, 5'b10000}, {6'b000011, 5'b10000}, {6'b000000, 5'b10110},
    {6'b000010, 5'b00101}, {6'b110000, 5'b10000}, {6'b000001, 5'b10110},
    {6'b000011, 5'b00101}, {6'b000000, 5'b00101}
  };

  function automatic string row_req(int r);
    case (r)
      1, 6, 11, 12, 15, 19: return "R2";
      2, 3, 7:              return "R4";
      8, 13, 17, 20:        return "R3";
      4, 5, 10, 14, 16, 18, 21: return "R5";
      default:              return "R11";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    tick(3);
    // R1 reset values
    check("R1 mode", mode_state, 0);
    check("R1 clk_en", clk_en, 1);
    check("R1 irq", wake_irq, 0);
    check("R1 part_en", part_en, 0);
    check("R1 tx_pin", tx_pin, 0);
    check("R1 rx_core", rx_core, 0);
    check("R1 loops", {dig_loop_active, ana_loop_active}, 0);
    rst = 0;

    for (int r = 0; r < NV; r++) begin
      {cpu_stop_req, cpu_wait_req, wait_clk_stop, eof_valid, irq_clear, rx_pin} = VEC[r][10:5];
      tick(1);
      check({row_req(r), " mode"}, mode_state, VEC[r][4:3]);
      check({row_req(r), " clk_en"}, clk_en, VEC[r][2]);
      check({row_req(r), " irq"}, wake_irq, VEC[r][1]);
      check({row_req(r), " part_en"}, part_en, VEC[r][0]);
    end
    {cpu_stop_req, cpu_wait_req, wait_clk_stop, eof_valid, irq_clear, rx_pin} = '0;

    // Digital loopback
    tick(310);
    dig_loop_req = 1;
    tick(2);
    check("R9 dig applied on idle", dig_loop_active, 1);
    tx_core = 1;
    tick(1);
    check("R7 tx_pin passive", tx_pin, 0);
    check("R6 rx_core loops tx", rx_core, 1);
    check("R11 part_en in run", part_en, 1);
    tx_core = 0; rx_pin = 1;
    tick(1);
    check("R6 rx_pin ignored", rx_core, 0);
    rx_pin = 0;

    // Change during activity
    tx_core = 1;
    tick(2);
    dig_loop_req = 0;
    tick(20);
    check("R9 held while busy", dig_loop_active, 1);
    tx_core = 0;
    tick(310);
    check("R9 released on idle", dig_loop_active, 0);
    tx_core = 1;
    tick(1);
    check("R6 tx_pin follows", tx_pin, 1);
    check("R6 rx_core follows pin", rx_core, 0);
    tx_core = 0;

    // Analog loopback
    tick(310);
    ana_loop_req = 1;
    tick(2);
    check("R9 ana applied", ana_loop_active, 1);
    check("R8 part_en in ana", part_en, 1);
    tx_core = 1;
    tick(1);
    check("R8 tx_pin follows", tx_pin, 1);
    rx_pin = 1;
    tick(1);
    check("R8 rx_core follows", rx_core, 1);
    rx_pin = 0; tx_core = 0;
    tick(310);
    ana_loop_req = 0;
    tick(2);
    check("R9 ana removed", ana_loop_active, 0);
    check("R10 holdoff start", part_en, 0);
    tick(150);
    check("R10 holdoff mid", part_en, 0);
    tick(200);
    check("R10 holdoff end", part_en, 1);

    // Holdoff restarted by activity
    ana_loop_req = 1;
    tick(2);
    ana_loop_req = 0;
    tick(2);
    check("R10 holdoff again", part_en, 0);
    tick(100);
    rx_pin = 1;
    tick(5);
    rx_pin = 0;
    tick(250);
    check("R10 restarted count", part_en, 0);
    tick(80);
    check("R10 restarted end", part_en, 1);

    finish_run();
  end
endmodule